// File: doc/BRIEF.md
# Pipelined Execute Stage with Result Forwarding and Branch Flush

This block is the third stage of a four-stage in-order pipeline. It accepts one decoded instruction per cycle (opcode, destination index, two source indices, the two operand values read from the register file at decode, an immediate and a branch target). It computes the result and hands the result and destination index to the store stage through a single output register.

Instructions never stall on a register dependence. The stage remembers the destination index and result of the last instruction that wrote a register. If an incoming source index matches that entry, the saved result replaces the stale operand that decode read. Branches resolve here. When a branch is taken, the stage raises a one-cycle flush together with the target address. Fetch loads that address as its next program counter, and the upstream stages discard everything younger than the branch.

Top module: `exe_stage`

## Requirements
- R1: After reset, out_valid_o is 0, flush_o is 0 and the forwarding entry is empty, so the first instruction uses the operand values it was given.
- R2: Opcode 0 (move) writes imm_i to destination rd_i. The result appears on out_data_o/out_rd_o with out_valid_o high in the cycle after the instruction is accepted.
- R3: Opcode 1 (add) produces the sum of its two effective operands, modulo 2^DATA_W, one cycle after acceptance.
- R4: If the forwarding entry is valid and rs1_i equals its index, the first operand is replaced by the saved result.
- R5: If the forwarding entry is valid and rs2_i equals its index, the second operand is replaced. The two substitutions are independent and may both apply.
- R6: A source index that does not match the valid forwarding entry uses the operand value supplied at decode.
- R7: The forwarding entry holds only the most recent register-writing instruction that was accepted. A newer write to the same index replaces the older value.
- R8: Opcode 2 (branch if zero) is taken when its effective first operand is zero. flush_o is high in the same cycle the branch is accepted, and redirect_pc_o equals target_i in that cycle. flush_o stays low at every other time.
- R9: A branch produces no store output (out_valid_o is 0 in the next cycle). A branch that is not taken leaves the forwarding entry unchanged.
- R10: A taken branch clears the forwarding entry, so the next instruction is not forwarded.
- R11: in_ready_o is high exactly when the output register is empty or out_ready_i is high. An instruction is accepted only when in_valid_i and in_ready_o are both high. While out_valid_o is high and out_ready_i is low, the output holds.
- R12: Opcode 3 is accepted and consumed with no store output, no flush and no change to the forwarding entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Decoded instruction present |
| in_ready_o | output | 1 | Stage can accept an instruction this cycle |
| op_i | input | 2 | Opcode: 0 move, 1 add, 2 branch if zero, 3 no effect |
| rd_i | input | REG_AW | Destination register index |
| rs1_i | input | REG_AW | First source register index |
| rs2_i | input | REG_AW | Second source register index |
| opa_i | input | DATA_W | First operand value read at decode |
| opb_i | input | DATA_W | Second operand value read at decode |
| imm_i | input | DATA_W | Immediate for move |
| target_i | input | PC_W | Branch target address |
| out_valid_o | output | 1 | Result valid toward store stage |
| out_ready_i | input | 1 | Store stage accepts the result |
| out_rd_o | output | REG_AW | Destination index of the result |
| out_data_o | output | DATA_W | Result value |
| flush_o | output | 1 | Taken-branch pulse that invalidates younger instructions |
| redirect_pc_o | output | PC_W | Next fetch address, valid with flush_o |

## Verification
Random instruction streams draw their source indices from a small register set, so a source that matches the forwarding entry is common. These streams separate first-only, second-only, both and no-match substitution. Branch operands are zero about half the time, which exposes taken and not-taken behaviour. A taken branch followed by a matching dependent instruction shows whether the forwarding entry was cleared. Random out_ready_i backpressure shows whether a result held in the output register survives, and whether acceptance obeys the ready rule. Directed sequences cover reset, the newest-writer rule with two back-to-back writes to one index, and the reserved opcode.

// File: rtl/exe_pkg.sv
package exe_pkg;
  typedef enum logic [1:0] {
    OPC_MOV = 2'd0,
    OPC_ADD = 2'd1,
    OPC_BRZ = 2'd2,
    OPC_RSV = 2'd3
  } opc_e;
endpackage

// File: rtl/exe_fwd_unit.sv
module exe_fwd_unit #(
  parameter int DATA_W = 16,
  parameter int REG_AW = 3,
  parameter int NSRC   = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          upd_i,
  input  logic [REG_AW-1:0]             upd_rd_i,
  input  logic [DATA_W-1:0]             upd_val_i,
  input  logic                          clr_i,
  input  logic [NSRC-1:0][REG_AW-1:0]   src_idx_i,
  input  logic [NSRC-1:0][DATA_W-1:0]   src_val_i,
  output logic [NSRC-1:0][DATA_W-1:0]   src_val_o
);
  logic              ent_v_q;
  logic [REG_AW-1:0] ent_rd_q;
  logic [DATA_W-1:0] ent_val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_v_q   <= 1'b0;
      ent_rd_q  <= '0;
      ent_val_q <= '0;
    end else if (clr_i) begin
      ent_v_q   <= 1'b0;
    end else if (upd_i) begin
      ent_v_q   <= 1'b1;
      ent_rd_q  <= upd_rd_i;
      ent_val_q <= upd_val_i;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic hit;
    assign hit          = ent_v_q && (src_idx_i[g] == ent_rd_q);
    assign src_val_o[g] = hit ? ent_val_q : src_val_i[g];
  end
endmodule

// File: rtl/exe_alu.sv
module exe_alu
  import exe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  opc_e              opc_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] imm_i,
  output logic              wr_o,
  output logic              taken_o,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    wr_o    = 1'b0;
    taken_o = 1'b0;
    res_o   = '0;
    unique case (opc_i)
      OPC_MOV: begin wr_o = 1'b1; res_o = imm_i;     end
      OPC_ADD: begin wr_o = 1'b1; res_o = a_i + b_i; end
      OPC_BRZ: taken_o = (a_i == '0);
      default: ;
    endcase
  end
endmodule

// File: rtl/exe_out_reg.sv
module exe_out_reg #(
  parameter int DATA_W = 16,
  parameter int REG_AW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] rd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              out_ready_i,
  output logic              accept_o,
  output logic              out_valid_o,
  output logic [REG_AW-1:0] out_rd_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic v_q;

  assign accept_o    = !v_q || out_ready_i;
  assign out_valid_o = v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q        <= 1'b0;
      out_rd_o   <= '0;
      out_data_o <= '0;
    end else if (fire_i) begin
      v_q <= wr_i;
      if (wr_i) begin
        out_rd_o   <= rd_i;
        out_data_o <= data_i;
      end
    end else if (out_ready_i) begin
      v_q <= 1'b0;
    end
  end
endmodule

// File: rtl/exe_stage.sv
module exe_stage
  import exe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_AW = 3,
  parameter int PC_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [1:0]        op_i,
  input  logic [REG_AW-1:0] rd_i,
  input  logic [REG_AW-1:0] rs1_i,
  input  logic [REG_AW-1:0] rs2_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [PC_W-1:0]   target_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [REG_AW-1:0] out_rd_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              flush_o,
  output logic [PC_W-1:0]   redirect_pc_o
);
  localparam int NSRC = 2;

  logic                        fire, wr, taken;
  logic [DATA_W-1:0]           res;
  logic [NSRC-1:0][REG_AW-1:0] src_idx;
  logic [NSRC-1:0][DATA_W-1:0] src_raw, src_eff;

  assign src_idx = {rs2_i, rs1_i};
  assign src_raw = {opb_i, opa_i};
  assign fire    = in_valid_i && in_ready_o;

  exe_fwd_unit #(.DATA_W(DATA_W), .REG_AW(REG_AW), .NSRC(NSRC)) u_fwd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (fire && wr),
    .upd_rd_i  (rd_i),
    .upd_val_i (res),
    .clr_i     (flush_o),
    .src_idx_i (src_idx),
    .src_val_i (src_raw),
    .src_val_o (src_eff)
  );

  exe_alu #(.DATA_W(DATA_W)) u_alu (
    .opc_i   (opc_e'(op_i)),
    .a_i     (src_eff[0]),
    .b_i     (src_eff[1]),
    .imm_i   (imm_i),
    .wr_o    (wr),
    .taken_o (taken),
    .res_o   (res)
  );

  exe_out_reg #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .wr_i        (wr),
    .rd_i        (rd_i),
    .data_i      (res),
    .out_ready_i (out_ready_i),
    .accept_o    (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_rd_o    (out_rd_o),
    .out_data_o  (out_data_o)
  );

  // Same-cycle flush so upstream kills younger work before it advances.
  assign flush_o       = fire && taken;
  assign redirect_pc_o = flush_o ? target_i : '0;
endmodule

// File: rtl/exe_stage_chk.sv
module exe_stage_chk #(
  parameter int DATA_W = 16,
  parameter int REG_AW = 3,
  parameter int PC_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [1:0]        op_i,
  input logic [REG_AW-1:0] rd_i,
  input logic [REG_AW-1:0] rs1_i,
  input logic [REG_AW-1:0] rs2_i,
  input logic [DATA_W-1:0] imm_i,
  input logic [PC_W-1:0]   target_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [REG_AW-1:0] out_rd_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              flush_o,
  input logic [PC_W-1:0]   redirect_pc_o
);
  logic acc;
  assign acc = in_valid_i && in_ready_o;

  p_hold_out_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_rd_o));

  p_no_accept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  p_flush_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> acc && op_i == 2'd2 && redirect_pc_o == target_i);

  p_no_store_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_i[1] |=> !out_valid_o);

  p_mov_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_i == 2'd0 |=> out_valid_o && out_data_o == $past(imm_i) && out_rd_o == $past(rd_i));

  // R5: back-to-back dependent add doubles the previous result
  p_fwd_both_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(acc && !op_i[1]) && acc && op_i == 2'd1 &&
    rs1_i == $past(rd_i) && rs2_i == $past(rd_i)
    |=> out_data_o == {$past(out_data_o[DATA_W-2:0]), 1'b0});
endmodule

bind exe_stage exe_stage_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW), .PC_W(PC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .op_i(op_i), .rd_i(rd_i), .rs1_i(rs1_i), .rs2_i(rs2_i), .imm_i(imm_i),
  .target_i(target_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_rd_o(out_rd_o), .out_data_o(out_data_o), .flush_o(flush_o),
  .redirect_pc_o(redirect_pc_o)
);

// File: tb/tb_exe_stage.sv
module tb_exe_stage;
  localparam int DW = 16, AW = 3, PW = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0, in_ready_o, out_valid_o, out_ready_i = 1'b0, flush_o;
  logic [1:0] op_i = '0;
  logic [AW-1:0] rd_i = '0, rs1_i = '0, rs2_i = '0, out_rd_o;
  logic [DW-1:0] opa_i = '0, opb_i = '0, imm_i = '0, out_data_o;
  logic [PW-1:0] target_i = '0, redirect_pc_o;

  int total = 0, bad = 0;

  // bench model
  logic          m_ov;
  logic [AW-1:0] m_ord;
  logic [DW-1:0] m_odat;
  string         m_tag;
  logic          f_v;
  logic [AW-1:0] f_rd;
  logic [DW-1:0] f_val;

  always #2 clk_i = ~clk_i;

  exe_stage #(.DATA_W(DW), .REG_AW(AW), .PC_W(PW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] eff(input logic [AW-1:0] rs, input logic [DW-1:0] v);
    return (f_v && rs == f_rd) ? f_val : v;
  endfunction

  // called just after a negedge; drives, checks, advances model, waits next negedge
  task automatic cyc(input logic v, input logic [1:0] op, input logic [AW-1:0] rd, rs1, rs2,
                     input logic [DW-1:0] a, b, imm, input logic [PW-1:0] tgt, input logic rdy);
    logic [DW-1:0] ea, eb;
    logic exp_rdy, fire, exp_fl;
    string ftag;
    in_valid_i = v; op_i = op; rd_i = rd; rs1_i = rs1; rs2_i = rs2;
    opa_i = a; opb_i = b; imm_i = imm; target_i = tgt; out_ready_i = rdy;
    #1;
    ea = eff(rs1, a);
    eb = eff(rs2, b);
    exp_rdy = !m_ov || rdy;
    fire    = v && exp_rdy;
    exp_fl  = fire && op == 2'd2 && ea == '0;
    chk(in_ready_o == exp_rdy, "R11 in_ready", 32'(in_ready_o), 32'(exp_rdy));
    chk(flush_o == exp_fl, "R8 flush", 32'(flush_o), 32'(exp_fl));
    if (exp_fl) chk(redirect_pc_o == tgt, "R8 redirect", 32'(redirect_pc_o), 32'(tgt));
    chk(out_valid_o == m_ov, m_tag, 32'(out_valid_o), 32'(m_ov));
    if (m_ov && out_valid_o) begin
      chk(out_rd_o == m_ord, m_tag, 32'(out_rd_o), 32'(m_ord));
      chk(out_data_o == m_odat, m_tag, 32'(out_data_o), 32'(m_odat));
    end
    if (fire) begin
      case (op)
        2'd0: begin
          m_ov = 1'b1; m_ord = rd; m_odat = imm; m_tag = "R2 move";
        end
        2'd1: begin
          m_ov = 1'b1; m_ord = rd; m_odat = ea + eb;
          ftag = "R3 R6 add";
          if (f_v && rs1 == f_rd && rs2 == f_rd) ftag = "R4 R5 both";
          else if (f_v && rs1 == f_rd) ftag = "R4 first";
          else if (f_v && rs2 == f_rd) ftag = "R5 second";
          m_tag = ftag;
        end
        2'd2: begin m_ov = 1'b0; m_tag = "R9 branch"; end
        default: begin m_ov = 1'b0; m_tag = "R12 reserved"; end
      endcase
      if (op == 2'd0 || op == 2'd1) begin
        f_v = 1'b1; f_rd = rd; f_val = m_odat;
      end else if (exp_fl) begin
        f_v = 1'b0;
      end
    end else if (rdy) begin
      m_ov = 1'b0;
    end
    @(negedge clk_i);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_ov = 0; m_ord = '0; m_odat = '0; m_tag = "R1 reset";
    f_v = 0; f_rd = '0; f_val = '0;
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R1 out_valid", 32'(out_valid_o), 0);
    chk(flush_o == 1'b0, "R1 flush", 32'(flush_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: no forwarding right after reset (rs=0 matches reset index value)
    cyc(1, 2'd1, 3'd2, 3'd0, 3'd0, 16'd3, 16'd4, 16'd0, 8'd0, 1);
    // R7: two writes to r1, newest wins
    cyc(1, 2'd0, 3'd1, 3'd0, 3'd0, 16'd0, 16'd0, 16'd5, 8'd0, 1);
    cyc(1, 2'd0, 3'd1, 3'd0, 3'd0, 16'd0, 16'd0, 16'd9, 8'd0, 1);
    cyc(1, 2'd1, 3'd2, 3'd1, 3'd1, 16'd1, 16'd1, 16'd0, 8'd0, 1);
    chk(out_data_o == 16'd18, "R7 newest", 32'(out_data_o), 32'd18);
    // R9: not-taken branch on r2 (=18) keeps entry; R12 reserved opcode
    cyc(1, 2'd2, 3'd0, 3'd2, 3'd0, 16'd0, 16'd0, 16'd0, 8'h44, 1);
    cyc(1, 2'd3, 3'd2, 3'd0, 3'd0, 16'd0, 16'd0, 16'd0, 8'd0, 1);
    cyc(1, 2'd1, 3'd3, 3'd2, 3'd0, 16'd7, 16'd1, 16'd0, 8'd0, 1);
    chk(out_data_o == 16'd19, "R9 R12 entry kept", 32'(out_data_o), 32'd19);
    // R8 R10: taken branch (operand forwarded zero via move), then no forward
    cyc(1, 2'd0, 3'd4, 3'd0, 3'd0, 16'd0, 16'd0, 16'd0, 8'd0, 1);
    cyc(1, 2'd2, 3'd0, 3'd4, 3'd0, 16'd5, 16'd0, 16'd0, 8'hA5, 1);
    cyc(1, 2'd1, 3'd5, 3'd4, 3'd4, 16'd6, 16'd2, 16'd0, 8'd0, 1);
    chk(out_data_o == 16'd8, "R10 cleared", 32'(out_data_o), 32'd8);
    // R11: stall output, then release
    cyc(1, 2'd0, 3'd6, 3'd0, 3'd0, 16'd0, 16'd0, 16'd77, 8'd0, 0);
    cyc(1, 2'd0, 3'd7, 3'd0, 3'd0, 16'd0, 16'd0, 16'd88, 8'd0, 0);
    cyc(1, 2'd0, 3'd7, 3'd0, 3'd0, 16'd0, 16'd0, 16'd88, 8'd0, 1);
    cyc(0, 2'd0, 3'd0, 3'd0, 3'd0, 16'd0, 16'd0, 16'd0, 8'd0, 1);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [DW-1:0] a, b;
      a = ($urandom_range(0, 1) == 0) ? 16'd0 : 16'($urandom);
      b = 16'($urandom);
      cyc($urandom_range(0, 9) < 8, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 3)),
          3'($urandom_range(0, 3)), 3'($urandom_range(0, 3)), a, b, 16'($urandom),
          8'($urandom), $urandom_range(0, 9) < 7);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule